// File: doc/BRIEF.md
# Wireless MAC header classifier

This block reads the opening bytes of a received 802.11 MPDU from a byte stream that carries start, valid and last strobes. From those bytes it works out a 7-bit software frame-group code and a set of per-frame attribute flags:

- multicast/broadcast
- directed
- power management
- more data
- order
- management type
- control type
- end of service period
- fragment

Four BSSID values and the station's own address are static inputs. Two further inputs are sampled with the start byte of each frame: an NDP sideband bit and a first-MSDU indicator.

Only the bytes the decision needs are stored. Once the last byte that matters has been accepted, the results are registered and a one-cycle done pulse marks them valid. For QoS data frames that byte is index 24. For all other frames it is index 22. A frame that ends earlier triggers the result at its last byte. Bytes after that point, and bytes that arrive while no frame is open, are ignored.

Top module: `wmac_hdr_classifier`

## Requirements
- R1: When the NDP input sampled with the start byte is 1, the group code is 0, whatever the header holds.
- R2: Otherwise a protocol version (byte 0 bits 1:0) other than zero, or a type (byte 0 bits 3:2) of 3, gives group code 36.
- R3: A data frame (type 2) gives code 3 when its subtype (byte 0 bits 7:4) is 4 or 12. Any other data frame gives code 1 when bit 0 of address 1 (byte 4 bit 0) is set, and code 2 when it is clear.
- R4: A management frame (type 0) gives code 4 plus its subtype, and the management-type flag reads 1.
- R5: A control frame (type 1) gives code 20 plus its subtype, and the control-type flag reads 1.
- R6: The power-management, more-data and order flags copy byte 1 bits 4, 5 and 7. The fragment flag is 1 when byte 1 bit 2 is set or when the low nibble of byte 22 is nonzero.
- R7: For a QoS data frame (type 2 with subtype bit 3 set), the EOSP flag copies byte 24 bit 4. For every other frame it reads 0.
- R8: The multicast/broadcast flag is 1 only when address 1 bit 0 is set and address 3 equals one of the four BSSID inputs. Addresses occupy bytes 4..9 and 16..21, and the first byte received is the least significant.
- R9: The directed flag is 1 when address 1 equals the own-address input.
- R10: When the first-MSDU input sampled with the start byte is 0, every flag reads 0. The group code is still produced.
- R11: Done is high for one cycle, two clock edges after the edge that accepts the trigger byte. The trigger byte is byte 24 for QoS data frames and byte 22 for all other frames, or the last byte if it comes first. A frame gives exactly one done. Later bytes of the frame, and valid bytes with no open frame, are ignored.
- R12: A header field beyond the last byte of a short frame is taken as zero. After reset the outputs are zero, and they change only in the cycle in which done is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_start | input | 1 | Marks the first byte of a frame (with in_valid) |
| in_valid | input | 1 | Byte strobe |
| in_last | input | 1 | Marks the final byte of a frame (with in_valid) |
| in_byte | input | 8 | Frame byte |
| ndp_in | input | 1 | NDP sideband, sampled with the start byte |
| first_msdu_in | input | 1 | First-MSDU indicator, sampled with the start byte |
| bssid_list | input | NUM_BSSID*48 | Programmed BSSID values |
| own_addr | input | 48 | Own-station address |
| done | output | 1 | One-cycle result pulse |
| group_code | output | 7 | Software frame-group code |
| mcast_flag | output | 1 | Group-addressed frame in a matched BSS |
| directed_flag | output | 1 | Receiver address equals own address |
| pwr_mgmt_flag | output | 1 | Power-management bit |
| more_data_flag | output | 1 | More-data bit |
| order_flag | output | 1 | Order bit |
| mgmt_flag | output | 1 | Management frame |
| ctrl_flag | output | 1 | Control frame |
| eosp_flag | output | 1 | End of service period |
| frag_flag | output | 1 | Fragment frame |

## Verification
The assertions assume that reset is held for at least two edges before any byte arrives. They also assume that in_valid is driven to a known value in every cycle, so that done can always be traced back to an accepted byte two edges earlier.

The stimulus keeps to this. It asserts reset over several cycles and drives every strobe low between frames. Frames are separated by idle gaps, so one frame's done pulse never overlaps the next frame's trigger. Random frames mix every type and version, addresses that hit the own address or a BSSID, and short lengths, with idle gaps between bytes.

// File: rtl/wmhc_pkg.sv
package wmhc_pkg;

  localparam int ADDR_W     = 48;
  localparam int ADDR_BYTES = ADDR_W / 8;
  localparam int FC0_POS    = 0;
  localparam int FC1_POS    = 1;
  localparam int RA_POS     = 4;
  localparam int BSS_POS    = 16;
  localparam int SEQ_POS    = 22;
  localparam int QOS_POS    = 24;
  localparam int HDR_SPAN   = QOS_POS + 1;

  localparam logic [6:0] GRP_NDP   = 7'd0;
  localparam logic [6:0] GRP_MCAST = 7'd1;
  localparam logic [6:0] GRP_UCAST = 7'd2;
  localparam logic [6:0] GRP_NULL  = 7'd3;
  localparam logic [6:0] GRP_MGMT  = 7'd4;
  localparam logic [6:0] GRP_CTRL  = 7'd20;
  localparam logic [6:0] GRP_UNSUP = 7'd36;

  typedef enum logic [1:0] {
    FT_MGMT = 2'd0,
    FT_CTRL = 2'd1,
    FT_DATA = 2'd2,
    FT_RSVD = 2'd3
  } ftype_e;

  typedef struct packed {
    logic mcast;
    logic directed;
    logic pwr_mgmt;
    logic more_data;
    logic order;
    logic mgmt;
    logic ctrl;
    logic eosp;
    logic frag;
  } attr_t;

  function automatic logic is_qos_data(input logic [7:0] fc0);
    return (ftype_e'(fc0[3:2]) == FT_DATA) && fc0[7];
  endfunction

  function automatic logic [6:0] frame_group(input logic ndp,
                                             input logic [7:0] fc0,
                                             input logic ra_group);
    logic [6:0] code;
    ftype_e     t;
    t = ftype_e'(fc0[3:2]);
    if (ndp)
      code = GRP_NDP;
    else if (fc0[1:0] != 2'd0 || t == FT_RSVD)
      code = GRP_UNSUP;
    else if (t == FT_MGMT)
      code = GRP_MGMT + {3'd0, fc0[7:4]};
    else if (t == FT_CTRL)
      code = GRP_CTRL + {3'd0, fc0[7:4]};
    else if (fc0[7:4] == 4'd4 || fc0[7:4] == 4'd12)
      code = GRP_NULL;
    else if (ra_group)
      code = GRP_MCAST;
    else
      code = GRP_UCAST;
    return code;
  endfunction

endpackage

// File: rtl/wmhc_capture.sv
module wmhc_capture
  import wmhc_pkg::*;
#(
  parameter int SPAN  = HDR_SPAN,
  localparam int IDX_W = $clog2(SPAN + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_start,
  input  logic              in_valid,
  input  logic              in_last,
  input  logic [7:0]        in_byte,
  input  logic              ndp_in,
  input  logic              first_in,
  output logic [7:0]        fc0_q,
  output logic [3:0]        fc1_q,
  output logic [ADDR_W-1:0] ra_q,
  output logic [ADDR_W-1:0] bss_q,
  output logic [3:0]        fragno_q,
  output logic              eosp_q,
  output logic              ndp_q,
  output logic              first_q,
  output logic              pend_q
);

  logic [IDX_W-1:0] idx_q;
  logic             open_q;
  logic [IDX_W-1:0] cur_idx;
  logic [IDX_W-1:0] need_idx;
  logic             accept;
  logic             fire;

  always_comb begin
    cur_idx  = in_start ? '0 : idx_q;
    accept   = in_valid && (in_start || open_q);
    need_idx = is_qos_data(fc0_q) ? IDX_W'(QOS_POS) : IDX_W'(SEQ_POS);
    fire     = accept && (in_last || (!in_start && cur_idx == need_idx));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q    <= '0;
      open_q   <= 1'b0;
      pend_q   <= 1'b0;
      fc0_q    <= '0;
      fc1_q    <= '0;
      ra_q     <= '0;
      bss_q    <= '0;
      fragno_q <= '0;
      eosp_q   <= 1'b0;
      ndp_q    <= 1'b0;
      first_q  <= 1'b0;
    end else begin
      pend_q <= fire;
      if (accept) begin
        open_q <= !fire;
        if (in_start) begin
          idx_q    <= IDX_W'(1);
          fc0_q    <= in_byte;
          fc1_q    <= '0;
          ra_q     <= '0;
          bss_q    <= '0;
          fragno_q <= '0;
          eosp_q   <= 1'b0;
          ndp_q    <= ndp_in;
          first_q  <= first_in;
        end else begin
          if (idx_q != IDX_W'(SPAN))
            idx_q <= idx_q + IDX_W'(1);
          if (cur_idx == IDX_W'(FC1_POS))
            fc1_q <= {in_byte[7], in_byte[5], in_byte[4], in_byte[2]};
          for (int k = 0; k < ADDR_BYTES; k++) begin
            if (cur_idx == IDX_W'(RA_POS + k))
              ra_q[8*k +: 8] <= in_byte;
            if (cur_idx == IDX_W'(BSS_POS + k))
              bss_q[8*k +: 8] <= in_byte;
          end
          if (cur_idx == IDX_W'(SEQ_POS))
            fragno_q <= in_byte[3:0];
          if (cur_idx == IDX_W'(QOS_POS))
            eosp_q <= in_byte[4];
        end
      end
    end
  end

endmodule

// File: rtl/wmhc_bssid_match.sv
module wmhc_bssid_match
  import wmhc_pkg::*;
#(
  parameter int NUM_BSSID = 4
) (
  input  logic [NUM_BSSID-1:0][ADDR_W-1:0] bssid_list,
  input  logic [ADDR_W-1:0]                bss_addr,
  output logic                             hit
);

  logic [NUM_BSSID-1:0] eq;

  for (genvar g = 0; g < NUM_BSSID; g++) begin : g_cmp
    assign eq[g] = (bssid_list[g] == bss_addr);
  end

  assign hit = |eq;

endmodule

// File: rtl/wmhc_classify.sv
module wmhc_classify
  import wmhc_pkg::*;
#(
  parameter int NUM_BSSID = 4
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             pend,
  input  logic [7:0]                       fc0,
  input  logic [3:0]                       fc1,
  input  logic [ADDR_W-1:0]                ra,
  input  logic [ADDR_W-1:0]                bss,
  input  logic [3:0]                       fragno,
  input  logic                             eosp_bit,
  input  logic                             ndp,
  input  logic                             first,
  input  logic [NUM_BSSID-1:0][ADDR_W-1:0] bssid_list,
  input  logic [ADDR_W-1:0]                own_addr,
  output logic                             done_q,
  output logic [6:0]                       group_q,
  output attr_t                            attr_q
);

  logic  bss_hit;
  attr_t attr_d;

  wmhc_bssid_match #(.NUM_BSSID(NUM_BSSID)) u_match (
    .bssid_list (bssid_list),
    .bss_addr   (bss),
    .hit        (bss_hit)
  );

  always_comb begin
    attr_d           = '0;
    attr_d.mcast     = ra[0] && bss_hit;
    attr_d.directed  = (ra == own_addr);
    attr_d.pwr_mgmt  = fc1[1];
    attr_d.more_data = fc1[2];
    attr_d.order     = fc1[3];
    attr_d.frag      = fc1[0] || (fragno != 4'd0);
    attr_d.mgmt      = ftype_e'(fc0[3:2]) == FT_MGMT;
    attr_d.ctrl      = ftype_e'(fc0[3:2]) == FT_CTRL;
    attr_d.eosp      = is_qos_data(fc0) && eosp_bit;
    if (!first)
      attr_d = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      done_q  <= 1'b0;
      group_q <= '0;
      attr_q  <= '0;
    end else begin
      done_q <= pend;
      if (pend) begin
        group_q <= frame_group(ndp, fc0, ra[0]);
        attr_q  <= attr_d;
      end
    end
  end

endmodule

// File: rtl/wmac_hdr_classifier.sv
module wmac_hdr_classifier
  import wmhc_pkg::*;
#(
  parameter int NUM_BSSID = 4
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             in_start,
  input  logic                             in_valid,
  input  logic                             in_last,
  input  logic [7:0]                       in_byte,
  input  logic                             ndp_in,
  input  logic                             first_msdu_in,
  input  logic [NUM_BSSID-1:0][ADDR_W-1:0] bssid_list,
  input  logic [ADDR_W-1:0]                own_addr,
  output logic                             done,
  output logic [6:0]                       group_code,
  output logic                             mcast_flag,
  output logic                             directed_flag,
  output logic                             pwr_mgmt_flag,
  output logic                             more_data_flag,
  output logic                             order_flag,
  output logic                             mgmt_flag,
  output logic                             ctrl_flag,
  output logic                             eosp_flag,
  output logic                             frag_flag
);

  logic [7:0]        fc0;
  logic [3:0]        fc1;
  logic [ADDR_W-1:0] ra;
  logic [ADDR_W-1:0] bss;
  logic [3:0]        fragno;
  logic              eosp_bit;
  logic              ndp_s;
  logic              first_s;
  logic              pend;
  attr_t             attr;

  wmhc_capture #(.SPAN(HDR_SPAN)) u_cap (
    .clk      (clk),
    .rst      (rst),
    .in_start (in_start),
    .in_valid (in_valid),
    .in_last  (in_last),
    .in_byte  (in_byte),
    .ndp_in   (ndp_in),
    .first_in (first_msdu_in),
    .fc0_q    (fc0),
    .fc1_q    (fc1),
    .ra_q     (ra),
    .bss_q    (bss),
    .fragno_q (fragno),
    .eosp_q   (eosp_bit),
    .ndp_q    (ndp_s),
    .first_q  (first_s),
    .pend_q   (pend)
  );

  wmhc_classify #(.NUM_BSSID(NUM_BSSID)) u_cls (
    .clk        (clk),
    .rst        (rst),
    .pend       (pend),
    .fc0        (fc0),
    .fc1        (fc1),
    .ra         (ra),
    .bss        (bss),
    .fragno     (fragno),
    .eosp_bit   (eosp_bit),
    .ndp        (ndp_s),
    .first      (first_s),
    .bssid_list (bssid_list),
    .own_addr   (own_addr),
    .done_q     (done),
    .group_q    (group_code),
    .attr_q     (attr)
  );

  assign mcast_flag     = attr.mcast;
  assign directed_flag  = attr.directed;
  assign pwr_mgmt_flag  = attr.pwr_mgmt;
  assign more_data_flag = attr.more_data;
  assign order_flag     = attr.order;
  assign mgmt_flag      = attr.mgmt;
  assign ctrl_flag      = attr.ctrl;
  assign eosp_flag      = attr.eosp;
  assign frag_flag      = attr.frag;

endmodule

// File: rtl/wmhc_checker.sv
module wmhc_checker (
  input logic       clk,
  input logic       rst,
  input logic       in_valid,
  input logic       done,
  input logic [6:0] group_code,
  input logic       mgmt_flag,
  input logic       ctrl_flag
);

  // R2: no code above the unsupported value
  assert_code_range_R2: assert property (@(posedge clk) disable iff (rst)
    group_code <= 7'd36);

  // R11: a done pulse traces back to an accepted byte two edges earlier
  assert_done_origin_R11: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(in_valid, 2));

  // R4: management flag only alongside a management code (or NDP/unsupported)
  assert_mgmt_code_R4: assert property (@(posedge clk) disable iff (rst)
    mgmt_flag |-> ((group_code >= 7'd4 && group_code <= 7'd19) ||
                   group_code == 7'd0 || group_code == 7'd36));

  // R5: control flag only alongside a control code (or NDP/unsupported)
  assert_ctrl_code_R5: assert property (@(posedge clk) disable iff (rst)
    ctrl_flag |-> ((group_code >= 7'd20 && group_code <= 7'd35) ||
                   group_code == 7'd0 || group_code == 7'd36));

  // R12: results hold between done pulses
  assert_result_hold_R12: assert property (@(posedge clk) disable iff (rst)
    !done |-> $stable(group_code));

  // R4 / R5: a frame is never both management and control
  assert_type_excl_R5: assert property (@(posedge clk) disable iff (rst)
    $onehot0({mgmt_flag, ctrl_flag}));

endmodule

bind wmac_hdr_classifier wmhc_checker u_chk (
  .clk        (clk),
  .rst        (rst),
  .in_valid   (in_valid),
  .done       (done),
  .group_code (group_code),
  .mgmt_flag  (mgmt_flag),
  .ctrl_flag  (ctrl_flag)
);

// File: tb/tb_wmac_hdr_classifier.sv
module tb_wmac_hdr_classifier;

  localparam int NB = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_start = 0, in_valid = 0, in_last = 0;
  logic [7:0] in_byte = 0;
  logic ndp_in = 0, first_msdu_in = 0;
  logic [NB-1:0][47:0] bssid_list;
  logic [47:0] own_addr;
  logic done;
  logic [6:0] group_code;
  logic mcast_flag, directed_flag, pwr_mgmt_flag, more_data_flag, order_flag;
  logic mgmt_flag, ctrl_flag, eosp_flag, frag_flag;

  wmac_hdr_classifier #(.NUM_BSSID(NB)) dut (
    .clk(clk), .rst(rst), .in_start(in_start), .in_valid(in_valid),
    .in_last(in_last), .in_byte(in_byte), .ndp_in(ndp_in),
    .first_msdu_in(first_msdu_in), .bssid_list(bssid_list),
    .own_addr(own_addr), .done(done), .group_code(group_code),
    .mcast_flag(mcast_flag), .directed_flag(directed_flag),
    .pwr_mgmt_flag(pwr_mgmt_flag), .more_data_flag(more_data_flag),
    .order_flag(order_flag), .mgmt_flag(mgmt_flag), .ctrl_flag(ctrl_flag),
    .eosp_flag(eosp_flag), .frag_flag(frag_flag)
  );

  always #10 clk = ~clk;

  int vectors = 0;
  int errors  = 0;
  int cyc     = 0;
  always @(posedge clk) cyc <= cyc + 1;

  logic [7:0] fb [0:31];
  int  flen;
  logic f_ndp, f_first;

  int  exp_cyc = 0;
  bit  exp_pend = 0;
  int  e_grp;
  logic [8:0] e_fl;
  string e_tag;

  task automatic chk(string tag, int act, int exp);
    vectors++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] gb(int i);
    return (i < flen) ? fb[i] : 8'h00;
  endfunction

  function automatic logic [47:0] gaddr(int p);
    logic [47:0] a;
    for (int k = 0; k < 6; k++) a[8*k +: 8] = gb(p + k);
    return a;
  endfunction

  function automatic bit qos_frame();
    return gb(0)[3:2] == 2'd2 && gb(0)[7];
  endfunction

  task automatic model();
    logic [7:0] b0, b1;
    logic [47:0] a1, a3;
    bit hit;
    b0 = gb(0); b1 = gb(1); a1 = gaddr(4); a3 = gaddr(16);
    hit = 0;
    for (int k = 0; k < NB; k++) if (bssid_list[k] == a3) hit = 1;
    if (f_ndp) begin e_grp = 0; e_tag = "R1"; end
    else if (b0[1:0] != 0 || b0[3:2] == 3) begin e_grp = 36; e_tag = "R2"; end
    else if (b0[3:2] == 0) begin e_grp = 4 + b0[7:4]; e_tag = "R4"; end
    else if (b0[3:2] == 1) begin e_grp = 20 + b0[7:4]; e_tag = "R5"; end
    else begin
      e_tag = "R3";
      if (b0[7:4] == 4 || b0[7:4] == 12) e_grp = 3;
      else e_grp = a1[0] ? 1 : 2;
    end
    // order: mcast directed pm md order mgmt ctrl eosp frag
    e_fl = {a1[0] & hit, a1 == own_addr, b1[4], b1[5], b1[7],
            b0[3:2] == 0, b0[3:2] == 1, qos_frame() & gb(24)[4],
            b1[2] | (gb(22)[3:0] != 0)};
    if (!f_first) e_fl = '0;
  endtask

  always @(negedge clk) begin
    if (!rst) begin
      if (exp_pend && cyc == exp_cyc) begin
        exp_pend = 0;
        chk("R11 done timing", done, 1);
        if (done) begin
          chk({e_tag, " group code"}, group_code, e_grp);
          chk(f_first ? "R8 mcast" : "R10 mcast gate", mcast_flag, e_fl[8]);
          chk(f_first ? "R9 directed" : "R10 directed gate", directed_flag, e_fl[7]);
          chk("R6 pwr_mgmt", pwr_mgmt_flag, e_fl[6]);
          chk("R6 more_data", more_data_flag, e_fl[5]);
          chk("R6 order", order_flag, e_fl[4]);
          chk("R4 mgmt flag", mgmt_flag, e_fl[3]);
          chk("R5 ctrl flag", ctrl_flag, e_fl[2]);
          chk("R7 eosp", eosp_flag, e_fl[1]);
          chk(flen < 24 ? "R12 frag short" : "R6 frag", frag_flag, e_fl[0]);
        end
      end else if (done) begin
        chk("R11 unexpected done", 1, 0);
      end
    end
  end

  // send fb[0..flen-1]; extra trailing bytes beyond flen are not part of frame
  task automatic send(bit gaps);
    int trig;
    trig = qos_frame() ? 24 : 22;
    if (flen - 1 < trig) trig = flen - 1;
    for (int i = 0; i < flen; i++) begin
      if (gaps) begin
        while ($urandom % 4 == 0) begin
          @(negedge clk);
          in_valid = 0; in_start = 0; in_last = 0;
        end
      end
      @(negedge clk);
      in_valid = 1; in_start = (i == 0); in_last = (i == flen - 1);
      in_byte = fb[i]; ndp_in = f_ndp; first_msdu_in = f_first;
      if (i == trig) begin
        model();
        exp_cyc = cyc + 2;
        exp_pend = 1;
      end
    end
    @(negedge clk);
    in_valid = 0; in_start = 0; in_last = 0; in_byte = 8'hA5;
    ndp_in = ~f_ndp; first_msdu_in = ~f_first;
    repeat (4) @(negedge clk);
  endtask

  task automatic base(logic [7:0] b0, logic [7:0] b1, int len);
    for (int i = 0; i < 32; i++) fb[i] = 8'($urandom);
    fb[0] = b0; fb[1] = b1; flen = len; f_ndp = 0; f_first = 1;
    fb[22] = {fb[22][7:4], 4'd0};
    for (int k = 0; k < 6; k++) fb[16 + k] = 8'($urandom);
  endtask

  task automatic put_addr(int p, logic [47:0] a);
    for (int k = 0; k < 6; k++) fb[p + k] = a[8*k +: 8];
  endtask

  initial begin : wd
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    for (int k = 0; k < NB; k++) bssid_list[k] = {16'h0A00 + 16'(k), 32'($urandom)};
    own_addr = {16'h1122, 32'($urandom)} & ~48'h1;
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk("R12 reset done", done, 0);
    chk("R12 reset group", group_code, 0);
    chk("R12 reset flags", {mcast_flag, directed_flag, pwr_mgmt_flag, more_data_flag,
        order_flag, mgmt_flag, ctrl_flag, eosp_flag, frag_flag}, 0);

    // R11: stray bytes with no open frame give no done
    for (int i = 0; i < 5; i++) begin
      @(negedge clk); in_valid = 1; in_byte = 8'($urandom);
    end
    @(negedge clk); in_valid = 0;
    repeat (4) @(negedge clk);

    // R1: NDP overrides a management header
    base(8'h80, 8'h00, 26); f_ndp = 1; send(0);
    // R2: version 1, and type 3
    base(8'h81, 8'h00, 26); send(0);
    base(8'h0C, 8'h00, 26); send(0);
    // R3: null and QoS null, multicast and unicast data
    base(8'h48, 8'h00, 26); send(0);
    base(8'hC8, 8'h00, 26); send(0);
    base(8'h08, 8'h00, 26); put_addr(4, 48'hFFFF_FFFF_FFFF); put_addr(16, bssid_list[2]); send(0);
    base(8'h08, 8'h00, 26); put_addr(4, own_addr); send(0);
    // R8: group address without BSSID match
    base(8'h08, 8'h00, 26); put_addr(4, 48'h01); put_addr(16, 48'h0BAD); send(0);
    // R4/R5 corners
    base(8'hF0, 8'hB4, 26); send(0);
    base(8'hF4, 8'h00, 26); send(0);
    // R7: QoS data with EOSP, triggered at byte 24
    base(8'h88, 8'h00, 30); fb[24] = 8'h10; send(1);
    // R6: fragment number only
    base(8'h08, 8'h00, 24); fb[22] = 8'h03; send(0);
    // R10: first-MSDU clear gates every flag
    base(8'h88, 8'hFF, 30); put_addr(4, own_addr); fb[24] = 8'hFF; f_first = 0; send(0);
    // R12: short frames, fields beyond end zero
    base(8'h08, 8'h04, 10); send(0);
    base(8'h88, 8'h00, 24); send(0);
    base(8'h40, 8'h00, 1); send(0);

    // random frames
    for (int n = 0; n < 400; n++) begin
      int r;
      logic [7:0] b0;
      b0 = 8'($urandom);
      if ($urandom % 8 != 0) b0[1:0] = 0;
      base(b0, 8'($urandom), 0);
      r = $urandom % 4;
      if (r == 0) put_addr(4, own_addr);
      else if (r == 1) put_addr(4, 48'hFFFF_FFFF_FFFF);
      else if (r == 2) put_addr(4, {32'($urandom), 16'($urandom)} | 48'h1);
      if ($urandom % 2 == 0) put_addr(16, bssid_list[$urandom % NB]);
      if ($urandom % 2 == 0) fb[22] = 8'($urandom);
      flen = ($urandom % 5 == 0) ? 1 + int'($urandom % 23) : 24 + int'($urandom % 7);
      f_ndp = ($urandom % 16 == 0);
      f_first = ($urandom % 4 != 0);
      send($urandom % 2 == 0);
    end

    repeat (4) @(negedge clk);
    if (exp_pend) chk("R11 missing done", 0, 1);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

endmodule